// File: doc/BRIEF.md
# Host Address Range Decoder

This block sorts every 32-bit host memory address into one of three destinations: main DRAM, the graphics port bus, or the hub interface. Software sets up the map through a small register port. One register gives the top of installed memory. Two pairs of registers each open an inclusive window onto the graphics bus. Two more registers place and size a naturally aligned graphics aperture. Aperture hits go to DRAM and carry a flag that says the address still needs translation.

A lookup is presented with `lk_valid` and `lk_addr`, and the result appears on the registered outputs one cycle later. The aperture wins over both windows, and the first window wins over the second. An address that misses all three goes to DRAM if it lies below top-of-memory. Otherwise it falls through to the hub interface. A registered error flag is raised whenever the aperture overlaps an enabled window. Placing the aperture directly next to a window is allowed.

Top module: `hostmem_route`

## Requirements
- R1: Register index 1 holds the first window base and index 2 its limit, each in write-data bits [31:20] at 1 MB granularity. An address with base*2^20 <= addr <= limit*2^20 + 0xFFFFF that misses the aperture returns target code 1 (graphics bus) with res_pref=0 and res_xlate=0.
- R2: Register indices 3 (base) and 4 (limit) set up the second window with the same inclusive test. A hit there that misses the aperture and the first window returns target code 1 with res_pref=1.
- R3: A window whose limit is below its base matches no address and never contributes to the configuration error.
- R4: Register index 6 holds the aperture size code in write-data bits [5:0]. 6'b111111 selects 4 MB. Each cleared low bit, counted upward from bit 0, doubles the size, so 6'b000000 selects 256 MB. Any other code acts as 256 MB. After reset the code is 6'b000000.
- R5: Register index 5 holds the aperture base in address form. A write stores only the bits at or above the current size, and bits below the current size always read as zero. Readback of indices 0 to 4 returns the field in bits [31:20] with zeros below. Index 6 reads back the raw code, and index 7 reads zero. Readback data appears one cycle after the index is presented.
- R6: An address inside the aperture returns target code 0 (DRAM) with res_xlate=1.
- R7: When ranges overlap, the aperture has priority over window 1, and window 1 has priority over window 2.
- R8: An address that hits no range returns target code 2 (hub) if addr[31:20] >= top-of-memory (register index 0, bits [31:20]). Otherwise it returns target code 0 with res_xlate=0.
- R9: cfg_err is 1 two cycles after the write that produces an overlap between the aperture and any enabled window. Adjacent ranges give cfg_err=0.
- R10: A lookup or readback in the same cycle as a register write uses the configuration from before that write.
- R11: After reset, res_valid and cfg_err are 0. Readback values are: top-of-memory 0, both bases 0xFFF00000, both limits 0, aperture base 0, size code 0.
- R12: res_valid is lk_valid delayed by exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register index for write and readback |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Registered readback of the indexed register |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 32 | Host address to classify |
| res_valid | output | 1 | Lookup result valid |
| res_tgt | output | 2 | Destination: 0 DRAM, 1 graphics bus, 2 hub |
| res_xlate | output | 1 | Aperture hit that needs translation |
| res_pref | output | 1 | Hit came from the second window |
| cfg_err | output | 1 | Aperture overlaps an enabled window |

## Verification
A register write and a lookup can land in the same clock cycle. The bench provokes this by writing a new top-of-memory value while it looks up an address that the old and new values classify differently. The lookup must follow the old map, and the next lookup of the same address must follow the new one. A readback of the written register in that same cycle must likewise return the old contents. Around this, the bench sweeps every 1 MB granule under several maps, using alternating low and high offsets, against an arithmetic model.

// File: rtl/hrd_pkg.sv
package hrd_pkg;

  typedef enum logic [1:0] {
    TGT_DRAM = 2'd0,
    TGT_GFX  = 2'd1,
    TGT_HUB  = 2'd2
  } tgt_e;

  typedef struct packed {
    tgt_e tgt;
    logic xlate;
    logic pref;
  } route_t;

  localparam int NWIN = 2;

  localparam logic [2:0] REG_TOM     = 3'd0;
  localparam logic [2:0] REG_W0_BASE = 3'd1;
  localparam logic [2:0] REG_W0_LIM  = 3'd2;
  localparam logic [2:0] REG_W1_BASE = 3'd3;
  localparam logic [2:0] REG_W1_LIM  = 3'd4;
  localparam logic [2:0] REG_AP_BASE = 3'd5;
  localparam logic [2:0] REG_AP_SIZE = 3'd6;

endpackage

// File: rtl/hrd_aperture.sv
module hrd_aperture #(
  parameter int ADDR_W    = 32,
  parameter int GRAN_LG   = 20,
  parameter int AP_MIN_LG = 22,
  parameter int AP_STEPS  = 6
) (
  input  logic [AP_STEPS-1:0]         size_code,
  input  logic [ADDR_W-AP_MIN_LG-1:0] base_q,
  input  logic [ADDR_W-AP_MIN_LG-1:0] addr_hi,
  output logic [ADDR_W-AP_MIN_LG-1:0] mask,
  output logic                        hit,
  output logic [ADDR_W-GRAN_LG-1:0]   lo_gran,
  output logic [ADDR_W-GRAN_LG-1:0]   hi_gran
);
  localparam int APW  = ADDR_W - AP_MIN_LG;
  localparam int SUBW = AP_MIN_LG - GRAN_LG;
  localparam logic [AP_STEPS-1:0] ONES = '1;

  logic [APW-1:0] eff;

  // Size code to a mask over the aperture-granular address bits.
  always_comb begin
    int lg;
    lg = AP_STEPS;
    for (int k = 0; k <= AP_STEPS; k++) begin
      if (size_code == (ONES << k)) lg = k;
    end
    for (int j = 0; j < APW; j++) begin
      mask[j] = (j >= lg);
    end
  end

  assign eff     = base_q & mask;
  assign hit     = (addr_hi & mask) == eff;
  assign lo_gran = {eff, {SUBW{1'b0}}};
  assign hi_gran = {eff | ~mask, {SUBW{1'b1}}};

endmodule

// File: rtl/hrd_window.sv
module hrd_window #(
  parameter int FW = 12
) (
  input  logic [FW-1:0] addr_hi,
  input  logic [FW-1:0] base,
  input  logic [FW-1:0] lim,
  input  logic [FW-1:0] ap_lo,
  input  logic [FW-1:0] ap_hi,
  output logic          en,
  output logic          hit,
  output logic          ovl
);
  assign en  = lim >= base;
  assign hit = (addr_hi >= base) && (addr_hi <= lim);
  assign ovl = en && (ap_lo <= lim) && (base <= ap_hi);
endmodule

// File: rtl/hrd_cfg.sv
module hrd_cfg import hrd_pkg::*; #(
  parameter int ADDR_W    = 32,
  parameter int GRAN_LG   = 20,
  parameter int AP_MIN_LG = 22,
  parameter int AP_STEPS  = 6
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               we,
  input  logic [2:0]                         addr,
  input  logic [ADDR_W-1:0]                  wdata,
  input  logic [ADDR_W-AP_MIN_LG-1:0]        ap_mask,
  output logic [ADDR_W-GRAN_LG-1:0]          tom_q,
  output logic [NWIN-1:0][ADDR_W-GRAN_LG-1:0] w_base,
  output logic [NWIN-1:0][ADDR_W-GRAN_LG-1:0] w_lim,
  output logic [ADDR_W-AP_MIN_LG-1:0]        ap_base_q,
  output logic [AP_STEPS-1:0]                ap_size_q,
  output logic [ADDR_W-1:0]                  rdata
);
  logic [ADDR_W-1:0] rd_n;
  logic              unused_wbits;

  assign unused_wbits = ^wdata[GRAN_LG-1:AP_STEPS];

  always_ff @(posedge clk) begin
    if (rst) begin
      tom_q     <= '0;
      w_base    <= '1;
      w_lim     <= '0;
      ap_base_q <= '0;
      ap_size_q <= '0;
    end else if (we) begin
      case (addr)
        REG_TOM:     tom_q     <= wdata[ADDR_W-1:GRAN_LG];
        REG_W0_BASE: w_base[0] <= wdata[ADDR_W-1:GRAN_LG];
        REG_W0_LIM:  w_lim[0]  <= wdata[ADDR_W-1:GRAN_LG];
        REG_W1_BASE: w_base[1] <= wdata[ADDR_W-1:GRAN_LG];
        REG_W1_LIM:  w_lim[1]  <= wdata[ADDR_W-1:GRAN_LG];
        REG_AP_BASE: ap_base_q <= wdata[ADDR_W-1:AP_MIN_LG] & ap_mask;
        REG_AP_SIZE: ap_size_q <= wdata[AP_STEPS-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_n = '0;
    case (addr)
      REG_TOM:     rd_n[ADDR_W-1:GRAN_LG]   = tom_q;
      REG_W0_BASE: rd_n[ADDR_W-1:GRAN_LG]   = w_base[0];
      REG_W0_LIM:  rd_n[ADDR_W-1:GRAN_LG]   = w_lim[0];
      REG_W1_BASE: rd_n[ADDR_W-1:GRAN_LG]   = w_base[1];
      REG_W1_LIM:  rd_n[ADDR_W-1:GRAN_LG]   = w_lim[1];
      REG_AP_BASE: rd_n[ADDR_W-1:AP_MIN_LG] = ap_base_q & ap_mask;
      REG_AP_SIZE: rd_n[AP_STEPS-1:0]       = ap_size_q;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_n;
  end

  // R5: low aperture-base bits never read back as ones
  p_apbase_low_zero_r5: assert property (@(posedge clk) disable iff (rst)
    addr == REG_AP_BASE |=> rdata[AP_MIN_LG-1:0] == '0);

endmodule

// File: rtl/hostmem_route.sv
module hostmem_route import hrd_pkg::*; #(
  parameter int ADDR_W    = 32,
  parameter int GRAN_LG   = 20,
  parameter int AP_MIN_LG = 22,
  parameter int AP_STEPS  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_addr,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic [ADDR_W-1:0] cfg_rdata,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              res_valid,
  output logic [1:0]        res_tgt,
  output logic              res_xlate,
  output logic              res_pref,
  output logic              cfg_err
);
  localparam int FW  = ADDR_W - GRAN_LG;
  localparam int APW = ADDR_W - AP_MIN_LG;

  logic [FW-1:0]            tom_q;
  logic [NWIN-1:0][FW-1:0]  w_base, w_lim;
  logic [APW-1:0]           ap_base_q, ap_mask;
  logic [AP_STEPS-1:0]      ap_size_q;
  logic [FW-1:0]            ap_lo, ap_hi, addr_hi;
  logic                     ap_hit, above_tom;
  logic [NWIN-1:0]          win_en, win_hit, win_ovl;
  route_t                   route_n, res_q;
  logic                     res_valid_q, cfg_err_q;
  logic                     unused_lo;

  assign addr_hi   = lk_addr[ADDR_W-1:GRAN_LG];
  assign unused_lo = ^lk_addr[GRAN_LG-1:0];

  hrd_cfg #(
    .ADDR_W(ADDR_W), .GRAN_LG(GRAN_LG), .AP_MIN_LG(AP_MIN_LG), .AP_STEPS(AP_STEPS)
  ) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .ap_mask(ap_mask), .tom_q(tom_q), .w_base(w_base), .w_lim(w_lim),
    .ap_base_q(ap_base_q), .ap_size_q(ap_size_q), .rdata(cfg_rdata)
  );

  hrd_aperture #(
    .ADDR_W(ADDR_W), .GRAN_LG(GRAN_LG), .AP_MIN_LG(AP_MIN_LG), .AP_STEPS(AP_STEPS)
  ) u_ap (
    .size_code(ap_size_q), .base_q(ap_base_q),
    .addr_hi(lk_addr[ADDR_W-1:AP_MIN_LG]), .mask(ap_mask), .hit(ap_hit),
    .lo_gran(ap_lo), .hi_gran(ap_hi)
  );

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    hrd_window #(.FW(FW)) u_win (
      .addr_hi(addr_hi), .base(w_base[w]), .lim(w_lim[w]),
      .ap_lo(ap_lo), .ap_hi(ap_hi),
      .en(win_en[w]), .hit(win_hit[w]), .ovl(win_ovl[w])
    );

    // R3: a disabled window never claims an address
    p_disabled_quiet_r3: assert property (@(posedge clk) disable iff (rst)
      !win_en[w] |-> !win_hit[w] && !win_ovl[w]);
  end

  assign above_tom = addr_hi >= tom_q;

  always_comb begin
    route_n = '{tgt: TGT_DRAM, xlate: 1'b0, pref: 1'b0};
    if (ap_hit)          route_n.xlate = 1'b1;
    else if (win_hit[0]) route_n.tgt   = TGT_GFX;
    else if (win_hit[1]) route_n = '{tgt: TGT_GFX, xlate: 1'b0, pref: 1'b1};
    else if (above_tom)  route_n.tgt   = TGT_HUB;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid_q <= 1'b0;
      res_q       <= '{tgt: TGT_DRAM, xlate: 1'b0, pref: 1'b0};
      cfg_err_q   <= 1'b0;
    end else begin
      res_valid_q <= lk_valid;
      if (lk_valid) res_q <= route_n;
      cfg_err_q   <= |win_ovl;
    end
  end

  assign res_valid = res_valid_q;
  assign res_tgt   = res_q.tgt;
  assign res_xlate = res_q.xlate;
  assign res_pref  = res_q.pref;
  assign cfg_err   = cfg_err_q;

  // R12: result valid follows the request by one cycle
  p_valid_follow_r12: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> res_valid);
  p_valid_idle_r12: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> !res_valid);
  // R6: translation flag only with the DRAM target
  p_xlate_dram_r6: assert property (@(posedge clk) disable iff (rst)
    res_valid && res_xlate |-> res_tgt == TGT_DRAM);
  // R2: second-window flag only with the graphics-bus target
  p_pref_gfx_r2: assert property (@(posedge clk) disable iff (rst)
    res_valid && res_pref |-> res_tgt == TGT_GFX && !res_xlate);
  // R8: hub target only at or above top-of-memory
  p_hub_above_tom_r8: assert property (@(posedge clk) disable iff (rst)
    res_valid && res_tgt == TGT_HUB |->
      $past(lk_addr[ADDR_W-1:GRAN_LG]) >= $past(tom_q));

endmodule

// File: tb/sim_hostmem_route.sv
module sim_hostmem_route;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = 3'd0;
  logic [31:0] cfg_wdata = 32'h0;
  logic [31:0] cfg_rdata;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_addr = 32'h0;
  logic        res_valid, res_xlate, res_pref, cfg_err;
  logic [1:0]  res_tgt;

  always #2 clk = ~clk;

  hostmem_route u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .lk_valid(lk_valid),
    .lk_addr(lk_addr), .res_valid(res_valid), .res_tgt(res_tgt),
    .res_xlate(res_xlate), .res_pref(res_pref), .cfg_err(cfg_err)
  );

  int n_chk = 0;
  int n_err = 0;

  logic [11:0] m_tom;
  logic [11:0] m_base [2];
  logic [11:0] m_lim  [2];
  logic [9:0]  m_apst;
  logic [5:0]  m_sz;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  endtask

  // Size in bytes from the code: trailing zeros t, valid when code + 2^t == 64.
  function automatic longint unsigned ap_bytes();
    int t;
    int lg;
    t = 0;
    while (t < 6 && m_sz[t] == 1'b0) t++;
    if (m_sz == 6'd0) lg = 6;
    else if ((int'(m_sz) + (1 << t)) == 64) lg = t;
    else lg = 6;
    return 64'd1 << (22 + lg);
  endfunction

  function automatic longint unsigned ap_lo_addr();
    longint unsigned b;
    b = ap_bytes();
    return ({32'h0, m_apst, 22'h0}) & ~(b - 1);
  endfunction

  function automatic bit win_hit(input int w, input logic [31:0] a);
    longint unsigned aa, lo, hi;
    aa = {32'h0, a};
    lo = {32'h0, m_base[w], 20'h00000};
    hi = {32'h0, m_lim[w], 20'hFFFFF};
    return aa >= lo && aa <= hi;
  endfunction

  // {tgt[1:0], xlate, pref}
  function automatic logic [3:0] route(input logic [31:0] a);
    longint unsigned aa, lo, b;
    aa = {32'h0, a};
    lo = ap_lo_addr();
    b  = ap_bytes();
    if (aa >= lo && aa < lo + b) return 4'b0010;
    if (win_hit(0, a)) return 4'b0100;
    if (win_hit(1, a)) return 4'b0101;
    if (a[31:20] >= m_tom) return 4'b1000;
    return 4'b0000;
  endfunction

  function automatic logic exp_err();
    longint unsigned alo, ahi, wlo, whi;
    logic e;
    e = 1'b0;
    alo = ap_lo_addr();
    ahi = alo + ap_bytes() - 1;
    for (int w = 0; w < 2; w++) begin
      wlo = {32'h0, m_base[w], 20'h00000};
      whi = {32'h0, m_lim[w], 20'hFFFFF};
      if (m_lim[w] >= m_base[w] && alo <= whi && wlo <= ahi) e = 1'b1;
    end
    return e;
  endfunction

  function automatic logic [31:0] exp_rd(input logic [2:0] idx);
    case (idx)
      3'd0: return {m_tom, 20'h0};
      3'd1: return {m_base[0], 20'h0};
      3'd2: return {m_lim[0], 20'h0};
      3'd3: return {m_base[1], 20'h0};
      3'd4: return {m_lim[1], 20'h0};
      3'd5: return ap_lo_addr()[31:0];
      3'd6: return {26'h0, m_sz};
      default: return 32'h0;
    endcase
  endfunction

  task automatic apply(input logic [2:0] idx, input logic [31:0] d);
    longint unsigned b;
    b = ap_bytes();
    case (idx)
      3'd0: m_tom     = d[31:20];
      3'd1: m_base[0] = d[31:20];
      3'd2: m_lim[0]  = d[31:20];
      3'd3: m_base[1] = d[31:20];
      3'd4: m_lim[1]  = d[31:20];
      3'd5: m_apst    = 10'((({32'h0, d}) & ~(b - 1)) >> 22);
      3'd6: m_sz      = d[5:0];
      default: ;
    endcase
  endtask

  task automatic wr(input logic [2:0] idx, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = idx; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    apply(idx, d);
  endtask

  task automatic rd(input logic [2:0] idx, input string tag);
    logic [31:0] e;
    e = exp_rd(idx);
    @(negedge clk);
    cfg_addr = idx;
    @(negedge clk);
    chk(cfg_rdata == e, $sformatf("%s readback idx %0d", tag, idx), cfg_rdata, e);
  endtask

  task automatic err_chk(input string tag);
    logic e;
    e = exp_err();
    @(negedge clk);
    chk(cfg_err == e, {tag, " cfg_err"}, {31'h0, cfg_err}, {31'h0, e});
  endtask

  task automatic look(input logic [31:0] a, input string tag);
    logic [3:0] e;
    logic [3:0] act;
    string t;
    e = route(a);
    if (e[1])             t = "R6/R7 aperture";
    else if (e == 4'b0100) t = "R1/R7 window1";
    else if (e == 4'b0101) t = "R2/R7 window2";
    else                   t = "R8 default";
    @(negedge clk);
    lk_valid = 1'b1; lk_addr = a;
    @(negedge clk);
    lk_valid = 1'b0;
    act = {res_tgt, res_xlate, res_pref};
    chk(res_valid && act == e, $sformatf("%s %s addr %h", tag, t, a),
        {27'h0, res_valid, act}, {27'h0, 1'b1, e});
  endtask

  task automatic sweep(input string tag);
    for (int g = 0; g < 4096; g++) begin
      look({g[11:0], (g % 2 == 1) ? 20'hFFFFF : 20'h00000}, tag);
    end
  endtask

  task automatic wr_look(input logic [2:0] idx, input logic [31:0] d,
                         input logic [31:0] a);
    logic [3:0]  e;
    logic [31:0] er;
    logic [3:0]  act;
    e  = route(a);
    er = exp_rd(idx);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = idx; cfg_wdata = d;
    lk_valid = 1'b1; lk_addr = a;
    @(negedge clk);
    cfg_we = 1'b0; lk_valid = 1'b0;
    act = {res_tgt, res_xlate, res_pref};
    chk(res_valid && act == e, "R10 lookup during write uses old map",
        {27'h0, res_valid, act}, {27'h0, 1'b1, e});
    chk(cfg_rdata == er, "R10 readback during write shows old value", cfg_rdata, er);
    apply(idx, d);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    m_tom = 12'h000; m_base[0] = 12'hFFF; m_lim[0] = 12'h000;
    m_base[1] = 12'hFFF; m_lim[1] = 12'h000; m_apst = 10'h0; m_sz = 6'h00;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R11: reset state
    @(negedge clk);
    chk(res_valid == 1'b0, "R11 res_valid after reset", {31'h0, res_valid}, 32'h0);
    chk(cfg_err == 1'b0, "R11 cfg_err after reset", {31'h0, cfg_err}, 32'h0);
    for (int i = 0; i < 8; i++) rd(3'(i), "R11");

    // R4: reset size is 256 MB at base 0; everything else goes to hub (TOM 0)
    look(32'h0FFF_FFFF, "R4 reset size top");
    look(32'h1000_0000, "R4 reset size end");
    @(negedge clk);
    chk(res_valid == 1'b0, "R12 valid drops after idle cycle", {31'h0, res_valid}, 32'h0);

    // Map A: separate, adjacent windows, 64 MB aperture at 2 GB
    wr(3'd0, 32'h2000_0000);
    wr(3'd1, 32'h3000_0000); wr(3'd2, 32'h37F0_0000);
    wr(3'd3, 32'h3800_0000); wr(3'd4, 32'h3FF0_0000);
    wr(3'd6, 32'h0000_0030); wr(3'd5, 32'h8000_0000);
    err_chk("R9 map A no overlap");
    for (int i = 0; i < 7; i++) rd(3'(i), "R5 map A");
    sweep("map A");

    // Map B: overlapping ranges exercise priority and raise the error
    wr(3'd0, 32'h4000_0000);
    wr(3'd1, 32'h8200_0000); wr(3'd2, 32'h8FF0_0000);
    wr(3'd3, 32'h8800_0000); wr(3'd4, 32'h9FF0_0000);
    err_chk("R9 map B overlap");
    sweep("map B");

    // Map C: window 1 adjacent to aperture, window 2 disabled across it
    wr(3'd1, 32'h8400_0000); wr(3'd2, 32'h84F0_0000);
    wr(3'd3, 32'h8100_0000); wr(3'd4, 32'h8000_0000);
    err_chk("R9/R3 map C adjacent and disabled");
    sweep("R3 map C");

    // R4/R5: every size code with an all-ones base write
    wr(3'd2, 32'h0000_0000);
    wr(3'd0, 32'h1000_0000);
    for (int k = 0; k <= 6; k++) begin
      logic [31:0] base;
      wr(3'd6, 32'(64 - (1 << k)));
      wr(3'd5, 32'hFFFF_FFFF);
      rd(3'd5, "R5 size sweep base");
      rd(3'd6, "R4 size sweep code");
      base = ap_lo_addr()[31:0];
      look(base, "R4 size sweep first");
      look(32'hFFFF_FFFF, "R4 size sweep last");
      look(base - 32'd1, "R4 size sweep below");
    end
    // R4: unused code acts as 256 MB
    wr(3'd6, 32'h0000_002A);
    wr(3'd5, 32'hFFFF_FFFF);
    rd(3'd5, "R4 unused code base");
    rd(3'd6, "R4 unused code raw");
    look(32'hF000_0000, "R4 unused code inside");
    look(32'hEFFF_FFFF, "R4 unused code outside");
    // R5: bits written under a large size stay zero after shrinking
    wr(3'd6, 32'h0000_0000);
    wr(3'd5, 32'hF7FF_FFFF);
    wr(3'd6, 32'h0000_003F);
    rd(3'd5, "R5 ignored low bits");
    look(32'hF03F_FFFF, "R5 shrunk aperture inside");
    look(32'hF040_0000, "R5 shrunk aperture outside");

    // R10: write top-of-memory while looking up an address it reclassifies
    wr(3'd0, 32'h1000_0000);
    rd(3'd0, "R10 setup");
    wr_look(3'd0, 32'h3000_0000, 32'h2000_0000);
    look(32'h2000_0000, "R10 after write");
    rd(3'd0, "R10 new value");

    finish_run();
  end

endmodule